// File: doc/BRIEF.md
# Addressable Latch with Demultiplex Mode

This block is a bank of eight storage bits with a single serial data input. A binary select value picks one bit. An active-low write enable and an active-high clear-all input together set one of four operating modes. In the write mode, the data input is stored into the selected bit. In the hold mode, the bank keeps its contents. In the clear mode, every output is forced low. In the demultiplex mode, only the selected output carries the data input and all others read zero. A common use is to turn a serial stream into a parallel word, one bit at a time. It can also steer a single strobe to one of eight destinations.

The block is fully synchronous. It samples its inputs on each rising clock edge, and its parallel output shows the result one cycle later. The design is sized by the width of the select input, so the bank holds `2**ADDR_W` bits. An optional monitor raises a one-cycle warning when the select value jumps by more than one bit between two back-to-back write cycles. A jump of that kind is unsafe in an asynchronous implementation of the same function.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zero and `skew_flag` becomes 0.
- R2: Write mode is `wr_en_n`=0 with `clr_all`=0. In this mode, `q[sel]` takes the value of `din` one cycle later, and every other bit of `q` keeps its value. The bit index is the unsigned binary value of `sel`.
- R3: Hold mode is `wr_en_n`=1 with `clr_all`=0. In this mode, `q` does not change for any value of `sel` or `din`, provided the previous cycle was not in demultiplex mode.
- R4: Clear mode is `clr_all`=1 with `wr_en_n`=1. In this mode, `q` is all zero one cycle later.
- R5: Demultiplex mode is `clr_all`=1 with `wr_en_n`=0. In this mode, one cycle later `q[sel]` equals `din` and every other bit of `q` is 0.
- R6: Leaving demultiplex mode leaves all stored bits cleared. If a hold cycle follows a demultiplex cycle, `q` is all zero.
- R7: A high `clr_all` never stores `din`. After a clear or demultiplex cycle, the bits written before that cycle read zero in hold mode.
- R8: `skew_flag` is high for exactly one cycle, in the cycle after the second of two consecutive write-mode cycles whose `sel` values differ in more than one bit position.
- R9: `skew_flag` stays low in two cases. The first is when two consecutive write cycles differ in at most one `sel` bit. The second is when either of the two cycles is not in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge system clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | ADDR_W | Binary index of the target bit |
| din | input | 1 | Serial data input |
| wr_en_n | input | 1 | Active-low write enable |
| clr_all | input | 1 | Active-high clear-all; with `wr_en_n` low it selects demultiplex mode |
| q | output | 2**ADDR_W | Parallel output bus |
| skew_flag | output | 1 | One-cycle warning of a multi-bit select jump between consecutive writes |

## Verification
The first pattern writes ones to the bits at both ends and in the middle, with hold cycles in between, and then writes a zero back. This separates a correct single-bit update from an update that disturbs its neighbours or decodes the wrong index. Hold cycles with a changing select and data input show that nothing leaks into the bank. Demultiplex cycles over several indices and both data values expose any stale contents on the unselected lines. The hold cycle after demultiplex, and the cycle after a clear, show whether the stored bits were wiped. The last pattern is a chain of writes whose select values differ by one bit, by two bits, and with a hold cycle in between, which tells a correct jump detector apart from one that fires too often or too rarely.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   // Encoding is {clr_all, wr_en_n}
   typedef enum logic [1:0] {
      MODE_WRITE = 2'b00,
      MODE_HOLD  = 2'b01,
      MODE_DEMUX = 2'b10,
      MODE_CLEAR = 2'b11
   } lat_mode_e;

endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
   import addr_latch_pkg::*;
(
   input  logic      wr_en_n,
   input  logic      clr_all,
   output lat_mode_e mode
);

   always_comb begin
      unique case ({clr_all, wr_en_n})
         2'b00:   mode = MODE_WRITE;
         2'b01:   mode = MODE_HOLD;
         2'b10:   mode = MODE_DEMUX;
         default: mode = MODE_CLEAR;
      endcase
   end

endmodule

// File: rtl/addr_latch_store.sv
module addr_latch_store
   import addr_latch_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int NUM_BITS = 8
)(
   input  logic                clk,
   input  logic                rst,
   input  lat_mode_e           mode,
   input  logic [ADDR_W-1:0]   sel,
   input  logic                din,
   output logic [NUM_BITS-1:0] store_q,
   output logic [NUM_BITS-1:0] demux_q
);

   if (NUM_BITS != (1 << ADDR_W)) begin : g_bad_size
      $error("addr_latch_store: NUM_BITS must equal 2**ADDR_W");
   end

   for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
      logic hit;
      logic keep_r;
      logic pass_r;

      assign hit = (sel == ADDR_W'(b));

      // Stored bit: any clear-class mode wipes it, so clear wins over write
      always_ff @(posedge clk) begin
         if (rst) begin
            keep_r <= 1'b0;
         end else begin
            unique case (mode)
               MODE_WRITE: if (hit) keep_r <= din;
               MODE_HOLD:  keep_r <= keep_r;
               default:    keep_r <= 1'b0;
            endcase
         end
      end

      // Demultiplexed copy: only the selected line may carry data
      always_ff @(posedge clk) begin
         if (rst) pass_r <= 1'b0;
         else     pass_r <= (mode == MODE_DEMUX) && hit && din;
      end

      assign store_q[b] = keep_r;
      assign demux_q[b] = pass_r;
   end

endmodule

// File: rtl/addr_latch_skew_mon.sv
module addr_latch_skew_mon
   import addr_latch_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter bit SKEW_DETECT = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  lat_mode_e         mode,
   input  logic [ADDR_W-1:0] sel,
   output logic              skew
);

   if (SKEW_DETECT) begin : g_mon
      logic [ADDR_W-1:0] prev_sel_r;
      logic              prev_wr_r;
      logic              skew_r;
      logic              cur_wr;
      logic              multi;

      function automatic int unsigned ones(input logic [ADDR_W-1:0] v);
         int unsigned n;
         n = 0;
         for (int i = 0; i < ADDR_W; i++) begin
            if (v[i]) n++;
         end
         return n;
      endfunction

      assign cur_wr = (mode == MODE_WRITE);
      assign multi  = ones(sel ^ prev_sel_r) > 1;

      always_ff @(posedge clk) begin
         if (rst) begin
            prev_sel_r <= '0;
            prev_wr_r  <= 1'b0;
            skew_r     <= 1'b0;
         end else begin
            prev_sel_r <= sel;
            prev_wr_r  <= cur_wr;
            skew_r     <= cur_wr && prev_wr_r && multi;
         end
      end

      assign skew = skew_r;
   end else begin : g_no_mon
      assign skew = 1'b0;
   end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
   import addr_latch_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter bit SKEW_DETECT = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       sel,
   input  logic                    din,
   input  logic                    wr_en_n,
   input  logic                    clr_all,
   output logic [(1<<ADDR_W)-1:0]  q,
   output logic                    skew_flag
);

   localparam int NUM_BITS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr_w
      $error("addr_latch_demux: ADDR_W must lie in 1..6");
   end

   lat_mode_e           mode;
   logic [NUM_BITS-1:0] store_q;
   logic [NUM_BITS-1:0] demux_q;
   logic                demux_view_r;

   addr_latch_mode_dec u_dec (
      .wr_en_n (wr_en_n),
      .clr_all (clr_all),
      .mode    (mode)
   );

   addr_latch_store #(
      .ADDR_W   (ADDR_W),
      .NUM_BITS (NUM_BITS)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .sel     (sel),
      .din     (din),
      .store_q (store_q),
      .demux_q (demux_q)
   );

   addr_latch_skew_mon #(
      .ADDR_W      (ADDR_W),
      .SKEW_DETECT (SKEW_DETECT)
   ) u_skew (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .sel  (sel),
      .skew (skew_flag)
   );

   // Remembers which copy drives the outputs during the current cycle
   always_ff @(posedge clk) begin
      if (rst) demux_view_r <= 1'b0;
      else     demux_view_r <= (mode == MODE_DEMUX);
   end

   assign q = demux_view_r ? demux_q : store_q;

endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
   parameter int ADDR_W = 3
)(
   input logic                   clk,
   input logic                   rst,
   input logic [ADDR_W-1:0]      sel,
   input logic                   din,
   input logic                   wr_en_n,
   input logic                   clr_all,
   input logic [(1<<ADDR_W)-1:0] q,
   input logic                   skew_flag
);

   localparam int NUM_BITS = 1 << ADDR_W;

   logic [1:0] armed_r;

   always_ff @(posedge clk) begin
      if (rst)                 armed_r <= 2'd0;
      else if (armed_r != 2'd3) armed_r <= armed_r + 2'd1;
   end

   AST_WRITE_BIT: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      $past(!wr_en_n && !clr_all) |-> q[$past(sel)] == $past(din)); // R2

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      ($past(wr_en_n && !clr_all) && $past(!(clr_all && !wr_en_n), 2)) |-> q == $past(q)); // R3

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      $past(clr_all && wr_en_n) |-> q == '0); // R4

   AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      $past(clr_all && !wr_en_n) |-> (q == (NUM_BITS'($past(din)) << $past(sel)))); // R5

   AST_DEMUX_EXIT_ZERO: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      ($past(wr_en_n && !clr_all) && $past(clr_all, 2)) |-> q == '0); // R6

   AST_SKEW_CAUSE: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      skew_flag |-> ($past(!wr_en_n && !clr_all) && $past(!wr_en_n && !clr_all, 2)
                     && $countones($past(sel) ^ $past(sel, 2)) > 1)); // R8

   AST_SKEW_PULSE: assert property (@(posedge clk) disable iff (rst || armed_r != 2'd3)
      skew_flag |=> (!skew_flag || $past(!wr_en_n && !clr_all))); // R9

endmodule

bind addr_latch_demux addr_latch_demux_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sel       (sel),
   .din       (din),
   .wr_en_n   (wr_en_n),
   .clr_all   (clr_all),
   .q         (q),
   .skew_flag (skew_flag)
);

// File: tb/addr_latch_demux_bench.sv
module addr_latch_demux_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] sel = 3'd3;
   logic       din = 1'b1;
   logic       wr_en_n = 1'b0;
   logic       clr_all = 1'b0;
   logic [7:0] q;
   logic       skew_flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_latch_demux u_addr_latch_demux (
      .clk       (clk),
      .rst       (rst),
      .sel       (sel),
      .din       (din),
      .wr_en_n   (wr_en_n),
      .clr_all   (clr_all),
      .q         (q),
      .skew_flag (skew_flag)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs; on return the outputs reflect them
   task automatic apply(input logic [2:0] s, input logic d, input logic en_n, input logic c);
      sel = s; din = d; wr_en_n = en_n; clr_all = c;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] s, input logic d);   apply(s, d, 1'b0, 1'b0); endtask
   task automatic hold(input logic [2:0] s, input logic d); apply(s, d, 1'b1, 1'b0); endtask
   task automatic clr();                                    apply(3'd5, 1'b1, 1'b1, 1'b1); endtask
   task automatic dmx(input logic [2:0] s, input logic d);  apply(s, d, 1'b0, 1'b1); endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 q in reset", q, 8'h00);
      check("R1 flag in reset", {7'b0, skew_flag}, 8'h00);
      rst = 1'b0;
      hold(3'd0, 1'b0);
      check("R1 q after reset", q, 8'h00);
   endtask

   task automatic t_write();
      wr(3'd0, 1'b1);   check("R2 write bit0", q, 8'h01);
      hold(3'd7, 1'b0);
      wr(3'd7, 1'b1);   check("R2 write bit7", q, 8'h81);
      hold(3'd3, 1'b0);
      wr(3'd3, 1'b1);   check("R2 write bit3", q, 8'h89);
      hold(3'd0, 1'b1);
      wr(3'd0, 1'b0);   check("R2 write zero bit0", q, 8'h88);
   endtask

   task automatic t_hold();
      hold(3'd5, 1'b1); check("R3 hold sel5 d1", q, 8'h88);
      hold(3'd2, 1'b0); check("R3 hold sel2 d0", q, 8'h88);
      hold(3'd7, 1'b0); check("R3 hold sel7 d0", q, 8'h88);
   endtask

   task automatic t_clear();
      clr();            check("R4 clear", q, 8'h00);
      hold(3'd3, 1'b1); check("R7 stored bits wiped by clear", q, 8'h00);
   endtask

   task automatic t_demux();
      wr(3'd1, 1'b1);   check("R2 write bit1", q, 8'h02);
      dmx(3'd4, 1'b1);  check("R5 demux sel4 d1", q, 8'h10);
      dmx(3'd6, 1'b0);  check("R5 demux sel6 d0", q, 8'h00);
      dmx(3'd2, 1'b1);  check("R5 demux sel2 d1", q, 8'h04);
      hold(3'd2, 1'b1); check("R6 hold after demux", q, 8'h00);
      check("R7 bit1 not kept through demux", {7'b0, q[1]}, 8'h00);
   endtask

   task automatic t_skew();
      wr(3'd0, 1'b1);   check("R9 no flag after hold", {7'b0, skew_flag}, 8'h00);
      wr(3'd3, 1'b1);   check("R8 flag on 0->3", {7'b0, skew_flag}, 8'h01);
      check("R2 bits 0 and 3", q, 8'h09);
      hold(3'd3, 1'b0); check("R8 flag lasts one cycle", {7'b0, skew_flag}, 8'h00);
      wr(3'd2, 1'b0);   check("R9 no flag after hold 3->2", {7'b0, skew_flag}, 8'h00);
      wr(3'd3, 1'b1);   check("R9 no flag one-bit change", {7'b0, skew_flag}, 8'h00);
      wr(3'd5, 1'b1);   check("R8 flag on 3->5", {7'b0, skew_flag}, 8'h01);
      check("R2 bits 0,3,5", q, 8'h29);
      dmx(3'd2, 1'b0);  check("R9 no flag into demux", {7'b0, skew_flag}, 8'h00);
   endtask

   initial begin
      t_reset();
      t_write();
      t_hold();
      t_clear();
      t_demux();
      t_skew();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule